// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block is a small, fully associative directory placed in front of a snooping interconnect. For each tracked cache line it keeps a tag and a presence vector with one bit per caching node. The vector marks every node that may hold a copy of the line. When a coherent request arrives, the filter works out which other nodes must be snooped. Only nodes whose presence bits are set receive a snoop, so a request is never broadcast to every node. The filter then updates its own record of the line.

When a line that is not yet tracked arrives and the table is full, one entry must be displaced. The displaced line is chosen by the number of owners it has: the entry with the fewest presence bits set goes first, because it costs the fewest back-invalidations. Ties are broken toward the least recently touched entry. A displaced entry produces a back-invalidate command, which carries its line tag and its owner vector. The command is held until the interconnect accepts it.

Nodes report silent drops of a line with eviction notices. These notices shrink the presence vectors and free entries that no longer have any owner.

Top module: `sharer_filter`

## Requirements
- R1: After reset, the table holds no valid entry. Immediately after reset `snoopValid` and `binvValid` are 0 and `reqReady` is 1.
- R2: A read that hits a tracked line returns, as `snoopMask`, the line's presence bits with the requester's bit cleared. The requester's bit is then added to the line. Bit n of every mask corresponds to node n.
- R3: A write (`reqWrite`=1) that hits a tracked line returns, as `snoopMask`, every other owner. Afterwards the line's vector holds only the writer's bit.
- R4: A request that misses allocates an entry whose vector holds only the requester's bit, and returns an all-zero `snoopMask`. A free entry is always used before any valid entry is displaced.
- R5: On a miss with no free entry, the victim is the valid entry whose presence vector has the fewest bits set.
- R6: Among entries that share that minimum count, the least recently used one is displaced. Every hit and every allocation makes the touched entry the most recent.
- R7: Displacing an entry raises `binvValid` with the victim's tag on `binvTag` and its vector on `binvMask`. Both stay stable until `binvReady` is seen high at a clock edge. While `binvValid` is high, `reqReady` is 0.
- R8: An eviction notice clears the notifying node's bit in the matching line. A line whose vector becomes all zero becomes free.
- R9: An eviction notice for an untracked line, or from a node that is not an owner, changes nothing.
- R10: A request is accepted at a clock edge where `reqValid` and `reqReady` are both 1. `snoopValid` is high for exactly the following cycle. `snoopMask` is zero whenever `snoopValid` is low. An eviction notice takes priority: `reqReady` is 0 while `evictValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Coherent request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqTag | input | 26 | Line tag of the request |
| reqNode | input | 2 | Requesting node |
| reqWrite | input | 1 | 1 = write, 0 = read |
| snoopValid | output | 1 | Snoop response for the request accepted last cycle |
| snoopMask | output | 4 | Nodes to snoop |
| evictValid | input | 1 | Eviction notice present |
| evictTag | input | 26 | Line tag being dropped |
| evictNode | input | 2 | Node dropping the line |
| binvValid | output | 1 | Back-invalidate pending |
| binvReady | input | 1 | Interconnect accepts the back-invalidate |
| binvTag | output | 26 | Tag of the displaced line |
| binvMask | output | 4 | Owners of the displaced line |

## Verification
The hardest case to reach from the ports is a full table in which several entries share the minimum owner count, because only their relative age then decides the victim. Directed sequences fill all sixteen entries from one node, then touch or enlarge selected lines before forcing a miss. Random traffic draws from a pool of 24 lines, which exceeds the table size, so displacement, tie breaks and eviction-freed entries occur many times. Each of these events is compared with a bench model of the table.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef struct packed {
    logic doReq;
    logic doEvict;
  } sfStrobe_t;
endpackage

// File: rtl/sf_datapath.sv
module sf_datapath
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NODES   = 4,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfStrobe_t         strobe,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [NODE_W-1:0] reqNode,
  input  logic              reqWrite,
  input  logic [TAG_W-1:0]  evictTag,
  input  logic [NODE_W-1:0] evictNode,
  output logic              hit,
  output logic [NODES-1:0]  hitVec,
  output logic              victimValid,
  output logic [TAG_W-1:0]  victimTag,
  output logic [NODES-1:0]  victimVec
);
  logic [TAG_W-1:0] tagQ [ENTRIES];
  logic [NODES-1:0] vecQ [ENTRIES];
  logic [IDX_W-1:0] ageQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;

  logic [TAG_W-1:0] lookupTag;
  logic [IDX_W-1:0] hitIdx, freeIdx, bestIdx, allocIdx, touchIdx;
  logic             freeAvail;
  logic [CNT_W-1:0] bestCnt;
  logic [IDX_W-1:0] bestAge;
  logic [NODES-1:0] reqBit, evictBit, evictVec;

  function automatic logic [CNT_W-1:0] popCount(input logic [NODES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int b = 0; b < NODES; b++) c = c + CNT_W'(v[b]);
    return c;
  endfunction

  assign lookupTag = strobe.doEvict ? evictTag : reqTag;
  assign reqBit    = NODES'(1) << reqNode;
  assign evictBit  = NODES'(1) << evictNode;

  // tag match; at most one valid entry holds a tag
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (validQ[i] && tagQ[i] == lookupTag) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  // lowest-numbered free entry
  always_comb begin
    freeAvail = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeAvail = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  // fewest owners first, oldest among equals (R5, R6)
  always_comb begin
    bestIdx = '0;
    bestCnt = popCount(vecQ[0]);
    bestAge = ageQ[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (popCount(vecQ[i]) < bestCnt ||
          (popCount(vecQ[i]) == bestCnt && ageQ[i] > bestAge)) begin
        bestIdx = IDX_W'(i);
        bestCnt = popCount(vecQ[i]);
        bestAge = ageQ[i];
      end
    end
  end

  assign allocIdx    = freeAvail ? freeIdx : bestIdx;
  assign touchIdx    = hit ? hitIdx : allocIdx;
  assign hitVec      = vecQ[hitIdx];
  assign evictVec    = vecQ[hitIdx] & ~evictBit;
  assign victimValid = strobe.doReq && !hit && !freeAvail;
  assign victimTag   = tagQ[bestIdx];
  assign victimVec   = vecQ[bestIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i] <= '0;
        vecQ[i] <= '0;
        ageQ[i] <= IDX_W'(i);
      end
    end else if (strobe.doReq) begin
      if (hit) begin
        vecQ[hitIdx] <= reqWrite ? reqBit : (vecQ[hitIdx] | reqBit);
      end else begin
        tagQ[allocIdx]   <= reqTag;
        vecQ[allocIdx]   <= reqBit;
        validQ[allocIdx] <= 1'b1;
      end
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == touchIdx)           ageQ[j] <= '0;
        else if (ageQ[j] < ageQ[touchIdx])   ageQ[j] <= ageQ[j] + 1'b1;
      end
    end else if (strobe.doEvict && hit) begin
      vecQ[hitIdx] <= evictVec;
      if (evictVec == '0) validQ[hitIdx] <= 1'b0;
    end
  end
endmodule

// File: rtl/sf_control.sv
module sf_control
  import sf_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int TAG_W   = 26,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NODE_W-1:0] reqNode,
  input  logic              evictValid,
  input  logic              binvReady,
  input  logic              hit,
  input  logic [NODES-1:0]  hitVec,
  input  logic              victimValid,
  input  logic [TAG_W-1:0]  victimTag,
  input  logic [NODES-1:0]  victimVec,
  output sfStrobe_t         strobe,
  output logic              reqReady,
  output logic              snoopValid,
  output logic [NODES-1:0]  snoopMask,
  output logic              binvValid,
  output logic [TAG_W-1:0]  binvTag,
  output logic [NODES-1:0]  binvMask
);
  logic [NODES-1:0] reqBit;

  assign reqBit         = NODES'(1) << reqNode;
  assign reqReady       = !binvValid && !evictValid;
  assign strobe.doEvict = evictValid;
  assign strobe.doReq   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snoopValid <= 1'b0;
      snoopMask  <= '0;
      binvValid  <= 1'b0;
      binvTag    <= '0;
      binvMask   <= '0;
    end else begin
      snoopValid <= strobe.doReq;
      snoopMask  <= (strobe.doReq && hit) ? (hitVec & ~reqBit) : '0;
      if (victimValid) begin
        binvValid <= 1'b1;
        binvTag   <= victimTag;
        binvMask  <= victimVec;
      end else if (binvValid && binvReady) begin
        binvValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sharer_filter.sv
module sharer_filter
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NODES   = 4,
  parameter int TAG_W   = 26,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [NODE_W-1:0] reqNode,
  input  logic              reqWrite,
  output logic              snoopValid,
  output logic [NODES-1:0]  snoopMask,
  input  logic              evictValid,
  input  logic [TAG_W-1:0]  evictTag,
  input  logic [NODE_W-1:0] evictNode,
  output logic              binvValid,
  input  logic              binvReady,
  output logic [TAG_W-1:0]  binvTag,
  output logic [NODES-1:0]  binvMask
);
  sfStrobe_t        strobe;
  logic             hit, victimValid;
  logic [NODES-1:0] hitVec, victimVec;
  logic [TAG_W-1:0] victimTag;

  sf_datapath #(.ENTRIES(ENTRIES), .NODES(NODES), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqTag(reqTag), .reqNode(reqNode), .reqWrite(reqWrite),
    .evictTag(evictTag), .evictNode(evictNode),
    .hit(hit), .hitVec(hitVec), .victimValid(victimValid),
    .victimTag(victimTag), .victimVec(victimVec)
  );

  sf_control #(.NODES(NODES), .TAG_W(TAG_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNode(reqNode),
    .evictValid(evictValid), .binvReady(binvReady),
    .hit(hit), .hitVec(hitVec), .victimValid(victimValid),
    .victimTag(victimTag), .victimVec(victimVec),
    .strobe(strobe), .reqReady(reqReady),
    .snoopValid(snoopValid), .snoopMask(snoopMask),
    .binvValid(binvValid), .binvTag(binvTag), .binvMask(binvMask)
  );
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int NODES   = 4,
  parameter int TAG_W   = 26,
  localparam int NODE_W = $clog2(NODES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [NODE_W-1:0] reqNode,
  input logic              evictValid,
  input logic              snoopValid,
  input logic [NODES-1:0]  snoopMask,
  input logic              binvValid,
  input logic              binvReady,
  input logic [TAG_W-1:0]  binvTag,
  input logic [NODES-1:0]  binvMask
);
  a_r7_binv_hold: assert property (@(posedge clk) disable iff (!rstN)
    binvValid && !binvReady |=> binvValid && $stable(binvTag) && $stable(binvMask));

  a_r7_stall_on_binv: assert property (@(posedge clk) disable iff (!rstN)
    binvValid |-> !reqReady);

  a_r10_evict_first: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> !reqReady);

  a_r10_quiet_mask: assert property (@(posedge clk) disable iff (!rstN)
    !snoopValid |-> snoopMask == '0);

  a_r2_no_self_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> (snoopMask & (NODES'(1) << $past(reqNode))) == '0);

  a_r5_victim_owned: assert property (@(posedge clk) disable iff (!rstN)
    binvValid |-> binvMask != '0);
endmodule

bind sharer_filter sf_checker #(.NODES(NODES), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .reqNode(reqNode),
  .evictValid(evictValid), .snoopValid(snoopValid), .snoopMask(snoopMask),
  .binvValid(binvValid), .binvReady(binvReady), .binvTag(binvTag),
  .binvMask(binvMask)
);

// File: tb/sharer_filter_tb.sv
module sharer_filter_tb;
  localparam int E = 16;
  localparam int N = 4;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqWrite = 0, evictValid = 0, binvReady = 0;
  logic [25:0] reqTag = 0, evictTag = 0;
  logic [1:0]  reqNode = 0, evictNode = 0;
  logic        reqReady, snoopValid, binvValid;
  logic [3:0]  snoopMask, binvMask;
  logic [25:0] binvTag;

  int nCmp = 0, nBad = 0, cyc = 0;

  int       mTag [E];
  bit [3:0] mVec [E];
  bit       mVal [E];
  int       mAge [E];

  sharer_filter u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nBad++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
        $finish;
      end
    end
  end

  function automatic int popc(input bit [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  function automatic void touch(input int idx);
    int old = mAge[idx];
    for (int j = 0; j < E; j++) if (j != idx && mAge[j] < old) mAge[j]++;
    mAge[idx] = 0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < E; i++) begin
      mVal[i] = 0; mVec[i] = 0; mTag[i] = 0; mAge[i] = i;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqValid = 0; evictValid = 0; binvReady = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    modelReset();
    #1;
    chk("R1 snoopValid", snoopValid, 0);
    chk("R1 binvValid", binvValid, 0);
    chk("R1 reqReady", reqReady, 1);
  endtask

  task automatic doReq(input string r, input int tag, input int node, input bit wr);
    bit [3:0] eMask = 0, bit1, bm = 0;
    bit bv = 0; int bt = 0, hi = -1, ai = -1;
    bit1 = 4'(1) << node;
    for (int i = 0; i < E; i++) if (mVal[i] && mTag[i] == tag) hi = i;
    if (hi >= 0) begin
      eMask = mVec[hi] & ~bit1;
      mVec[hi] = wr ? bit1 : (mVec[hi] | bit1);
      touch(hi);
    end else begin
      for (int i = E - 1; i >= 0; i--) if (!mVal[i]) ai = i;
      if (ai < 0) begin
        ai = 0;
        for (int i = 1; i < E; i++)
          if (popc(mVec[i]) < popc(mVec[ai]) ||
              (popc(mVec[i]) == popc(mVec[ai]) && mAge[i] > mAge[ai])) ai = i;
        bv = 1; bt = mTag[ai]; bm = mVec[ai];
      end
      mTag[ai] = tag; mVec[ai] = bit1; mVal[ai] = 1;
      touch(ai);
    end
    @(negedge clk);
    reqValid = 1; reqTag = 26'(tag); reqNode = 2'(node); reqWrite = wr;
    #1 chk("R10 ready before accept", reqReady, 1);
    @(negedge clk);
    reqValid = 0;
    chk({r, " R10 snoopValid"}, snoopValid, 1);
    chk({r, " snoopMask"}, snoopMask, eMask);
    chk("R7 binvValid", binvValid, bv);
    if (bv) begin
      chk("R5/R6 binvTag", binvTag, bt);
      chk("R7 binvMask", binvMask, bm);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk("R7 hold valid", binvValid, 1);
        chk("R7 hold tag", binvTag, bt);
        chk("R7 stall", reqReady, 0);
      end
      binvReady = 1;
      @(negedge clk);
      binvReady = 0;
      chk("R7 released", binvValid, 0);
      chk("R7 ready again", reqReady, 1);
    end
  endtask

  task automatic doEvict(input int tag, input int node);
    for (int i = 0; i < E; i++)
      if (mVal[i] && mTag[i] == tag) begin
        mVec[i] = mVec[i] & ~(4'(1) << node);
        if (mVec[i] == 0) mVal[i] = 0;
      end
    @(negedge clk);
    evictValid = 1; evictTag = 26'(tag); evictNode = 2'(node);
    #1 chk("R10 evict priority", reqReady, 0);
    @(negedge clk);
    evictValid = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    doReset();

    // R4: sixteen distinct lines fill free entries with no displacement
    for (int i = 0; i < E; i++) doReq("R4 fill", 100 + i, 0, 0);
    // R2 read hits collect owners
    doReq("R2 read hit", 103, 1, 0);
    doReq("R2 read hit", 103, 2, 0);
    // R3 write leaves only the writer
    doReq("R3 write hit", 103, 3, 1);
    doReq("R3 after write", 103, 0, 0);
    // R6: touch line 100, so 101 is the oldest single-owner line
    doReq("R6 touch", 100, 0, 0);
    doReq("R6 tie victim", 300, 1, 0);

    // R5: every line but 110 gets a second owner
    doReset();
    for (int i = 0; i < E; i++) doReq("R4 fill", 100 + i, 0, 0);
    for (int i = 0; i < E; i++) if (i != 10) doReq("R5 widen", 100 + i, 1, 0);
    doReq("R5 fewest owners", 301, 2, 0);

    // R8 / R9: eviction notices
    doReset();
    for (int i = 0; i < E; i++) doReq("R4 fill", 100 + i, 0, 0);
    doReq("R2 add owner", 105, 2, 0);
    doEvict(105, 0);
    doReq("R8 bit cleared", 105, 1, 0);
    doEvict(100, 3);
    doEvict(999, 1);
    doReq("R9 ignored notice", 100, 1, 0);
    doEvict(105, 1);
    doEvict(105, 2);
    doReq("R8 freed entry reused", 200, 3, 0);

    // random traffic over a pool larger than the table
    doReset();
    for (int k = 0; k < 3000; k++) begin
      int t = 500 + $urandom_range(0, 23);
      int n = $urandom_range(0, 3);
      if ($urandom_range(0, 9) < 2) doEvict(t, n);
      else doReq("R2/R3/R4/R6 random", t, n, $urandom_range(0, 9) < 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule